// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This unit compares two IEEE-754 operands and writes the result into a four-bit N, Z, C, V flag register. Flag bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. Each operand can be single or double precision. In single precision the value sits in the low 32 bits of the operand bus. Any NaN operand gives the unordered pattern. Otherwise the unit gives the less, equal or greater pattern, and the two signed zeros count as equal.

The unit has three working modes and one reserved encoding. The first mode compares operand A with operand B. The second compares operand A with positive zero and ignores operand B. The third is a conditional compare. It tests a condition code against the flags already held in the register. If the test passes, the comparison result is written. If the test fails, a four-bit immediate is written instead. This lets a chain of compares build a compound condition without branches.

The unit is a single datapath with one register. It has no state machine, and there are no states or transitions to name. A strobe on `valid_i` loads the flag register on the next rising clock edge. Without the strobe the register holds its value.

Top module: `fpcmp_flags`

## Requirements
- R1: While `rst_n` is low the flag register reads 0000, and after reset it stays 0000 until the first strobe.
- R2: A NaN is an operand whose exponent field is all ones and whose fraction is nonzero. The single-precision fields are exponent bits 30:23 and fraction bits 22:0. The double-precision fields are exponent bits 62:52 and fraction bits 51:0. If either compared operand is a NaN, quiet or signalling, the flags become 0011 whatever the other operand is.
- R3: For ordered operands the flags become 1000 when A < B, 0010 when A > B and 0110 when A == B. This includes infinities and subnormals.
- R4: Positive zero and negative zero compare as equal (0110).
- R5: `dbl_i` = 1 selects double precision on all 64 bits. `dbl_i` = 0 selects single precision on bits 31:0, and bits 63:32 have no effect.
- R6: `mode_i` = 01 compares A against positive zero, and `opb_i` has no effect.
- R7: `mode_i` = 10 is the conditional compare. The condition is tested on the current flags. If it passes, the flags take the A-versus-B result. If it fails, they take `imm_i`. The condition codes, by value of `cond_i`, are:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C & !Z
  - 9: !(C & !Z)
  - 10: N == V
  - 11: N != V
  - 12: !Z & (N == V)
  - 13: !(!Z & (N == V))
- R8: Condition codes 14 and 15 always pass.
- R9: A strobe on `valid_i` updates the flags on the next rising edge. Without the strobe the flags hold, whatever the other inputs do.
- R10: `mode_i` = 00 compares A against B. `mode_i` = 11 is reserved, and a strobe with it leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| dbl_i | input | 1 | 1 = double precision, 0 = single |
| mode_i | input | 2 | 00 register compare, 01 compare with zero, 10 conditional compare, 11 reserved |
| cond_i | input | 4 | Condition code for the conditional compare |
| imm_i | input | 4 | Flag value written when the condition fails |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| flags_o | output | 4 | Flag register {N,Z,C,V} |

## Verification
Operands are drawn from several groups: signed zeros, infinities, quiet and signalling NaNs, and finite values confined to a narrow exponent window. Operand B is often a copy of A or A with its sign flipped. These groups separate the four result patterns and catch a sign-handling error on near-equal magnitudes. Single-precision vectors carry random upper halves, which shows whether the precision select masks them. The conditional compare is run across all sixteen codes with whatever flags the previous vector left. This exercises both the pass path and the fail path. Idle and reserved-mode cycles with changing inputs show that the register holds.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    localparam int OP_W       = 64;
    localparam int FLAG_W     = 4;
    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int DP_EXP_W   = 11;
    localparam int DP_FRAC_W  = 52;
    localparam int SP_SIGN    = SP_EXP_W + SP_FRAC_W;
    localparam int DP_SIGN    = DP_EXP_W + DP_FRAC_W;
    localparam int MAG_W      = DP_SIGN;
    localparam int COND_W     = 4;
    localparam int N_OPND     = 2;

    typedef enum logic [1:0] {
        MODE_REG  = 2'b00,
        MODE_ZERO = 2'b01,
        MODE_COND = 2'b10,
        MODE_RSVD = 2'b11
    } cmp_mode_e;

    localparam logic [FLAG_W-1:0] FL_UNORD   = 4'b0011;
    localparam logic [FLAG_W-1:0] FL_LESS    = 4'b1000;
    localparam logic [FLAG_W-1:0] FL_EQUAL   = 4'b0110;
    localparam logic [FLAG_W-1:0] FL_GREATER = 4'b0010;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;
endpackage

// File: rtl/fpcmp_operand.sv
module fpcmp_operand
    import fpcmp_pkg::*;
(
    input  logic            dbl,
    input  logic [OP_W-1:0] raw,
    output opnd_t           info
);
    localparam int SP_PAD = MAG_W - SP_SIGN;

    always_comb begin
        if (dbl) begin
            info.sign = raw[DP_SIGN];
            info.mag  = raw[DP_SIGN-1:0];
            info.nan  = (&raw[DP_SIGN-1:DP_FRAC_W]) && (|raw[DP_FRAC_W-1:0]);
        end else begin
            info.sign = raw[SP_SIGN];
            info.mag  = {{SP_PAD{1'b0}}, raw[SP_SIGN-1:0]};
            info.nan  = (&raw[SP_SIGN-1:SP_FRAC_W]) && (|raw[SP_FRAC_W-1:0]);
        end
        info.zero = (info.mag == '0);
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  opnd_t             a,
    input  opnd_t             b,
    output logic [FLAG_W-1:0] flags
);
    logic mag_lt;

    always_comb begin
        mag_lt = (a.mag < b.mag);
        if (a.nan || b.nan) begin
            flags = FL_UNORD;
        end else if (a.zero && b.zero) begin
            flags = FL_EQUAL;
        end else if (a.sign != b.sign) begin
            flags = a.sign ? FL_LESS : FL_GREATER;
        end else if (a.mag == b.mag) begin
            flags = FL_EQUAL;
        end else begin
            flags = (mag_lt ^ a.sign) ? FL_LESS : FL_GREATER;
        end
    end

    AST_PATTERN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == FL_UNORD) || (flags == FL_LESS) ||
        (flags == FL_EQUAL) || (flags == FL_GREATER)); // R3

    AST_MIRROR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!a.nan && !b.nan && !a.zero && a.sign && !b.sign) |-> (flags == FL_LESS)); // R3
endmodule

// File: rtl/fpcmp_cond.sv
module fpcmp_cond
    import fpcmp_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [FLAG_W-1:0] nzcv,
    output logic              pass
);
    logic n, z, c, v, base;

    always_comb begin
        {n, z, c, v} = nzcv;
        unique case (cond[COND_W-1:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c && !z;
            3'd5: base = (n == v);
            3'd6: base = !z && (n == v);
            3'd7: base = 1'b1;
            default: base = 1'b1;
        endcase
        if (cond[COND_W-1:1] == 3'd7) pass = 1'b1;
        else                          pass = base ^ cond[0];
    end
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
    import fpcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              dbl_i,
    input  logic [1:0]        mode_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic [FLAG_W-1:0] imm_i,
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    output logic [FLAG_W-1:0] flags_o
);
    cmp_mode_e         mode;
    logic [OP_W-1:0]   raw   [N_OPND];
    opnd_t             opnd  [N_OPND];
    logic [FLAG_W-1:0] cmp_flags;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_d;
    logic              cond_pass;

    assign mode   = cmp_mode_e'(mode_i);
    assign raw[0] = opa_i;
    assign raw[1] = (mode == MODE_ZERO) ? '0 : opb_i;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
        fpcmp_operand u_dec (
            .dbl  (dbl_i),
            .raw  (raw[gi]),
            .info (opnd[gi])
        );
    end

    fpcmp_order u_order (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (opnd[0]),
        .b     (opnd[1]),
        .flags (cmp_flags)
    );

    fpcmp_cond u_cond (
        .cond (cond_i),
        .nzcv (flags_q),
        .pass (cond_pass)
    );

    always_comb begin
        unique case (mode)
            MODE_REG,
            MODE_ZERO: flags_d = cmp_flags;
            MODE_COND: flags_d = cond_pass ? cmp_flags : imm_i;
            MODE_RSVD: flags_d = flags_q;
            default:   flags_d = flags_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       flags_q <= '0;
        else if (valid_i) flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(flags_o)); // R9

    AST_RSVD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode == MODE_RSVD) |=> $stable(flags_o)); // R10

    AST_CCMP_FAIL_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode == MODE_COND && !cond_pass) |=> (flags_o == $past(imm_i))); // R7

    AST_NAN_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (mode == MODE_REG || mode == MODE_ZERO) && (opnd[0].nan || opnd[1].nan))
        |=> (flags_o == FL_UNORD)); // R2

    AST_ALWAYS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i[COND_W-1:1] == 3'd7) |-> cond_pass); // R8
endmodule

// File: tb/fpcmp_flags_tb.sv
`timescale 1ns/1ps
module fpcmp_flags_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [3:0]  cond_i = 4'h0;
    logic [3:0]  imm_i = 4'h0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic [3:0]  flags_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [3:0] model = 4'h0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fpcmp_flags u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .dbl_i(dbl_i),
        .mode_i(mode_i), .cond_i(cond_i), .imm_i(imm_i),
        .opa_i(opa_i), .opb_i(opb_i), .flags_o(flags_o)
    );

    function automatic bit is_nan(bit dbl, logic [63:0] x);
        if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic logic [64:0] order_key(bit dbl, logic [63:0] x);
        logic [64:0] m;
        bit s;
        m = dbl ? {2'b00, x[62:0]} : {34'd0, x[30:0]};
        s = dbl ? x[63] : x[31];
        if (m == 0) return 65'h1_0000_0000_0000_0000 >> 1;
        return s ? ((65'h1_0000_0000_0000_0000 >> 1) - m) : ((65'h1_0000_0000_0000_0000 >> 1) + m);
    endfunction

    function automatic logic [3:0] ref_cmp(bit dbl, logic [63:0] a, logic [63:0] b);
        logic [64:0] ka, kb;
        if (is_nan(dbl, a) || is_nan(dbl, b)) return 4'b0011;
        ka = order_key(dbl, a);
        kb = order_key(dbl, b);
        if (ka < kb) return 4'b1000;
        if (ka > kb) return 4'b0010;
        return 4'b0110;
    endfunction

    function automatic bit ref_cond(logic [3:0] c, logic [3:0] f);
        bit n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !(cy && !z);
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return !(!z && (n == v));
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [63:0] gen_op(bit dbl);
        logic [63:0] r;
        int k;
        r = {$urandom, $urandom};
        k = $urandom % 8;
        if (dbl) begin
            case (k)
                0: r[62:0] = '0;
                1: begin r[62:52] = 11'h7FF; r[51:0] = '0; end
                2: begin r[62:52] = 11'h7FF; if (r[51:0] == 0) r[0] = 1'b1; end
                3: r[62:52] = '0;
                default: r[62:52] = 11'h3FE + 11'($urandom % 3);
            endcase
        end else begin
            case (k)
                0: r[30:0] = '0;
                1: begin r[30:23] = 8'hFF; r[22:0] = '0; end
                2: begin r[30:23] = 8'hFF; if (r[22:0] == 0) r[0] = 1'b1; end
                3: r[30:23] = '0;
                default: r[30:23] = 8'h7E + 8'($urandom % 3);
            endcase
        end
        return r;
    endfunction

    task automatic check(string tag, logic [3:0] exp_f);
        n_vec++;
        if (flags_o !== exp_f) begin
            n_bad++;
            $display("FAIL %s: flags actual %b expected %b", tag, flags_o, exp_f);
        end
    endtask

    task automatic apply(string tag, bit dbl, logic [1:0] mode, logic [3:0] cond,
                         logic [3:0] imm, logic [63:0] a, logic [63:0] b);
        logic [3:0] res, exp_f;
        res = ref_cmp(dbl, a, (mode == 2'b01) ? 64'd0 : b);
        case (mode)
            2'b00, 2'b01: exp_f = res;
            2'b10:        exp_f = ref_cond(cond, model) ? res : imm;
            default:      exp_f = model;
        endcase
        @(negedge clk);
        dbl_i = dbl; mode_i = mode; cond_i = cond; imm_i = imm;
        opa_i = a; opb_i = b; valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        model = exp_f;
        check(tag, exp_f);
    endtask

    task automatic idle_check();
        @(negedge clk);
        valid_i = 1'b0; mode_i = 2'($urandom); cond_i = 4'($urandom);
        imm_i = 4'($urandom); opa_i = {$urandom, $urandom}; opb_i = {$urandom, $urandom};
        @(negedge clk);
        @(negedge clk);
        check("R9", model);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 4'b0000);

        apply("R3", 1'b0, 2'b00, 4'h0, 4'h0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000);
        apply("R3", 1'b1, 2'b00, 4'h0, 4'h0, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000);
        apply("R3", 1'b1, 2'b00, 4'h0, 4'h0, 64'hBFF0_0000_0000_0000, 64'hBFF0_0000_0000_0000);
        apply("R4", 1'b1, 2'b00, 4'h0, 4'h0, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000);
        apply("R4", 1'b0, 2'b00, 4'h0, 4'h0, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000);
        apply("R2", 1'b0, 2'b00, 4'h0, 4'h0, 64'h0000_0000_7F80_0000, 64'h0000_0000_7F80_0001);
        apply("R2", 1'b1, 2'b00, 4'h0, 4'h0, 64'hFFF8_0000_0000_0000, 64'h0000_0000_0000_0000);
        apply("R5", 1'b0, 2'b00, 4'h0, 4'h0, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0001_3F80_0000);
        apply("R6", 1'b0, 2'b01, 4'h0, 4'h0, 64'h0000_0000_BF80_0000, 64'h0000_0000_7FC0_0000);
        apply("R6", 1'b1, 2'b01, 4'h0, 4'h0, 64'h0000_0000_0000_0000, 64'hFFF0_0000_0000_0000);
        apply("R7", 1'b0, 2'b10, 4'h1, 4'b1010, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000);
        apply("R7", 1'b0, 2'b10, 4'h4, 4'b0101, 64'h0000_0000_4000_0000, 64'h0000_0000_3F80_0000);
        apply("R8", 1'b1, 2'b10, 4'hF, 4'b1111, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000);
        apply("R8", 1'b1, 2'b10, 4'hE, 4'b1111, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000);
        apply("R10", 1'b0, 2'b11, 4'h0, 4'b1111, 64'h0000_0000_7FC0_0000, 64'h0);
        idle_check();

        for (int i = 0; i < 3000; i++) begin
            bit dbl;
            logic [1:0] mode;
            logic [63:0] a, b;
            int pick;
            dbl = 1'($urandom);
            mode = 2'($urandom);
            a = gen_op(dbl);
            pick = $urandom % 4;
            b = (pick == 0) ? a : gen_op(dbl);
            if (pick == 1) begin
                if (dbl) b[63] = ~a[63]; else b[31] = ~a[31];
                b[62:0] = dbl ? a[62:0] : {b[62:31], a[30:0]};
            end
            case (mode)
                2'b00: apply("R3", dbl, mode, 4'($urandom), 4'($urandom), a, b);
                2'b01: apply("R6", dbl, mode, 4'($urandom), 4'($urandom), a, b);
                2'b10: apply("R7", dbl, mode, 4'($urandom), 4'($urandom), a, b);
                default: apply("R10", dbl, mode, 4'($urandom), 4'($urandom), a, b);
            endcase
            if (i % 200 == 0) idle_check();
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule